// File: doc/BRIEF.md
# General-Purpose Event Status and Routing Block

This block collects platform event sources into one 32-bit status register and pairs it with a 32-bit enable register. Sixteen GPIO pins, each with its own direction and polarity control, and one USB controller wake line set sticky status bits in hardware. Software reads both registers through a simple select/write port. It clears status bits by writing ones and leaves bits alone by writing zeros.

When an enabled status bit is set, the block signals it. While the platform sleeps, it raises a wake request. In the working state it raises either a system control interrupt or a system management interrupt, chosen by a global steering input. The status bits sit in two reset domains. The always-powered resume reset clears everything. A software-initiated platform reset clears only the GPIO half.

Top module: `gpe_ctrl`

## Requirements
- R1: While `rst_resume` is high (synchronous), the status and enable registers both become 32'h0000_0000 and all three event outputs are low.
- R2: A clock edge with `rst_plat` high clears status bits 31:16. It leaves status bits 15:0 and the whole enable register unchanged.
- R3: Status bit 16+n (n = 0..15) sets on an edge where `gpio_dir_in[n]` is 1 and `gpio_lvl[n] ^ gpio_inv[n]` is 1. A pin with `gpio_dir_in[n]` = 0 never sets its bit.
- R4: Status bit 8 sets on an edge where `usb_wake_req` is 1.
- R5: A register write with `reg_sel` = 0 clears every status bit whose write-data bit is 1 and keeps those whose write-data bit is 0. If a hardware set and a clear hit the same bit on the same edge, the bit stays set.
- R6: A set status bit stays set after its source condition goes away, until it is cleared by software or by a reset.
- R7: Bit positions 15:9 and 7:0 are reserved. In both registers they read as 0 and ignore writes.
- R8: `wake_o` is high exactly when `sleeping` is 1 and (status AND enable) is nonzero. A set status bit whose enable bit is 0 raises no output.
- R9: With `sleeping` = 0 and (status AND enable) nonzero, `sci_o` is high if `sci_sel` is 1 and `smi_o` is high if `sci_sel` is 0. At most one of `wake_o`, `sci_o` and `smi_o` is high at any time.
- R10: `reg_rdata` returns the status register when `reg_sel` = 0 and the enable register when `reg_sel` = 1, combinationally. A write with `reg_sel` = 1 loads the enable register at the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_resume | input | 1 | Resume-well synchronous reset, active high, clears everything |
| rst_plat | input | 1 | Platform synchronous reset, active high, clears GPIO status only |
| sleeping | input | 1 | 1 = platform in a sleep state, 0 = working state |
| sci_sel | input | 1 | 1 = route working-state events to SCI, 0 = to SMI |
| gpio_lvl | input | 16 | GPIO pin levels |
| gpio_dir_in | input | 16 | 1 = pin configured as input |
| gpio_inv | input | 16 | 1 = pin event on low level |
| usb_wake_req | input | 1 | USB controller wake request |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status register, 1 = enable register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| wake_o | output | 1 | Wake request |
| sci_o | output | 1 | System control interrupt |
| smi_o | output | 1 | System management interrupt |

## Verification
The hardest case to reach is a hardware set and a software clear landing on the same bit in the same cycle. The bench holds a GPIO input condition true and issues a write-one clear of that bit in the same cycle, then checks that the bit still reads as set. The split reset is also hard to observe, since it needs bits set in both halves at once. The bench sets a USB bit and several GPIO bits, loads the enable register, and then pulses the platform reset alone. It reads both registers back afterwards.

// File: rtl/gpe_pkg.sv
`timescale 1ns/1ps
package gpe_pkg;
    parameter int REG_W    = 32;
    parameter int NUM_GPIO = 16;
    parameter int GPIO_LSB = 16;
    parameter int USB_BIT  = 8;

    localparam logic [REG_W-1:0] GPIO_MASK  = {{NUM_GPIO{1'b1}}, {GPIO_LSB{1'b0}}};
    localparam logic [REG_W-1:0] USB_MASK   = {{(REG_W-1){1'b0}}, 1'b1} << USB_BIT;
    localparam logic [REG_W-1:0] VALID_MASK = GPIO_MASK | USB_MASK;

    typedef enum logic {SEL_STATUS = 1'b0, SEL_ENABLE = 1'b1} reg_sel_e;
    typedef enum logic {PWR_WORKING = 1'b0, PWR_SLEEP = 1'b1} pwr_state_e;

    typedef struct packed {
        logic [REG_W-1:0] set;
        logic [REG_W-1:0] clr;
    } sts_update_t;

    typedef struct packed {
        logic wake;
        logic sci;
        logic smi;
    } evt_out_t;

    function automatic logic pin_event(input logic lvl, input logic dir_in, input logic inv);
        return dir_in & (lvl ^ inv);
    endfunction
endpackage

// File: rtl/gpe_source_map.sv
`timescale 1ns/1ps
module gpe_source_map
    import gpe_pkg::*;
#(
    parameter int W      = REG_W,
    parameter int NG     = NUM_GPIO,
    parameter int G_LSB  = GPIO_LSB,
    parameter int U_BIT  = USB_BIT
) (
    input  logic [NG-1:0] gpio_lvl,
    input  logic [NG-1:0] gpio_dir_in,
    input  logic [NG-1:0] gpio_inv,
    input  logic          usb_wake_req,
    output logic [W-1:0]  set_vec
);
    logic [NG-1:0] pin_hit;

    for (genvar g = 0; g < NG; g++) begin : g_pin
        assign pin_hit[g] = pin_event(gpio_lvl[g], gpio_dir_in[g], gpio_inv[g]);
    end

    always_comb begin
        set_vec = '0;
        set_vec[G_LSB +: NG] = pin_hit;
        set_vec[U_BIT] = usb_wake_req;
    end
endmodule

// File: rtl/gpe_status_bank.sv
`timescale 1ns/1ps
module gpe_status_bank
    import gpe_pkg::*;
#(
    parameter int W                  = REG_W,
    parameter logic [W-1:0] VALID    = VALID_MASK,
    parameter logic [W-1:0] PLAT_DOM = GPIO_MASK
) (
    input  logic        clk,
    input  logic        rst_resume,
    input  logic        rst_plat,
    input  sts_update_t upd,
    output logic [W-1:0] sts
);
    logic [W-1:0] sts_next;

    always_comb begin
        // Set is applied after clear so a same-cycle set wins.
        sts_next = ((sts & ~upd.clr) | upd.set) & VALID;
        if (rst_plat) sts_next = sts_next & ~PLAT_DOM;
    end

    always_ff @(posedge clk) begin
        if (rst_resume) sts <= '0;
        else            sts <= sts_next;
    end

    p_reserved_zero_r7: assert property (@(posedge clk) disable iff (rst_resume)
        (sts & ~VALID) == '0);

    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst_resume)
        !rst_plat |=> ((sts & $past(upd.set & VALID)) == $past(upd.set & VALID)));

    p_w1c_r5: assert property (@(posedge clk) disable iff (rst_resume)
        1'b1 |=> ((sts & $past(upd.clr & ~upd.set)) == '0));

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst_resume)
        !rst_plat |=> ((sts & $past(sts & ~upd.clr)) == $past(sts & ~upd.clr)));

    p_plat_clear_r2: assert property (@(posedge clk) disable iff (rst_resume)
        rst_plat |=> ((sts & PLAT_DOM) == '0));
endmodule

// File: rtl/gpe_route.sv
`timescale 1ns/1ps
module gpe_route
    import gpe_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] sts,
    input  logic [W-1:0] en,
    input  pwr_state_e   pwr,
    input  logic         sci_sel,
    output evt_out_t     evt
);
    logic pending;

    always_comb begin
        pending  = |(sts & en);
        evt.wake = pending && (pwr == PWR_SLEEP);
        evt.sci  = pending && (pwr == PWR_WORKING) && sci_sel;
        evt.smi  = pending && (pwr == PWR_WORKING) && !sci_sel;
    end

    always_comb begin
        p_exclusive_r9: assert ($onehot0({evt.wake, evt.sci, evt.smi}));
        p_wake_needs_enable_r8: assert (!evt.wake || (sts & en) != '0);
    end
endmodule

// File: rtl/gpe_ctrl.sv
`timescale 1ns/1ps
module gpe_ctrl
    import gpe_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int NG = NUM_GPIO
) (
    input  logic          clk,
    input  logic          rst_resume,
    input  logic          rst_plat,
    input  logic          sleeping,
    input  logic          sci_sel,
    input  logic [NG-1:0] gpio_lvl,
    input  logic [NG-1:0] gpio_dir_in,
    input  logic [NG-1:0] gpio_inv,
    input  logic          usb_wake_req,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [W-1:0]  reg_wdata,
    output logic [W-1:0]  reg_rdata,
    output logic          wake_o,
    output logic          sci_o,
    output logic          smi_o
);
    reg_sel_e    sel;
    sts_update_t upd;
    logic [W-1:0] sts;
    logic [W-1:0] en;
    logic [W-1:0] set_vec;
    evt_out_t    evt;
    pwr_state_e  pwr;

    assign sel = reg_sel_e'(reg_sel);
    assign pwr = sleeping ? PWR_SLEEP : PWR_WORKING;

    gpe_source_map #(.W(W), .NG(NG)) u_map (
        .gpio_lvl     (gpio_lvl),
        .gpio_dir_in  (gpio_dir_in),
        .gpio_inv     (gpio_inv),
        .usb_wake_req (usb_wake_req),
        .set_vec      (set_vec)
    );

    always_comb begin
        upd.set = set_vec;
        upd.clr = (reg_wr && sel == SEL_STATUS) ? reg_wdata : '0;
    end

    gpe_status_bank #(.W(W)) u_bank (
        .clk        (clk),
        .rst_resume (rst_resume),
        .rst_plat   (rst_plat),
        .upd        (upd),
        .sts        (sts)
    );

    always_ff @(posedge clk) begin
        if (rst_resume)                         en <= '0;
        else if (reg_wr && sel == SEL_ENABLE)   en <= reg_wdata & VALID_MASK;
    end

    gpe_route #(.W(W)) u_route (
        .sts     (sts),
        .en      (en),
        .pwr     (pwr),
        .sci_sel (sci_sel),
        .evt     (evt)
    );

    assign reg_rdata = (sel == SEL_ENABLE) ? en : sts;
    assign wake_o    = evt.wake;
    assign sci_o     = evt.sci;
    assign smi_o     = evt.smi;

    p_en_reserved_r7: assert property (@(posedge clk) disable iff (rst_resume)
        (en & ~VALID_MASK) == '0);

    p_en_kept_on_plat_r2: assert property (@(posedge clk) disable iff (rst_resume)
        (rst_plat && !reg_wr) |=> (en == $past(en)));

    p_wake_sleep_r8: assert property (@(posedge clk) disable iff (rst_resume)
        wake_o |-> sleeping);
endmodule

// File: tb/test_gpe_ctrl.sv
`timescale 1ns/1ps
module test_gpe_ctrl;
    logic        clk = 1'b0;
    logic        rst_resume, rst_plat, sleeping, sci_sel;
    logic [15:0] gpio_lvl, gpio_dir_in, gpio_inv;
    logic        usb_wake_req, reg_wr, reg_sel;
    logic [31:0] reg_wdata, reg_rdata;
    logic        wake_o, sci_o, smi_o;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    gpe_ctrl i_gpe_ctrl (
        .clk(clk), .rst_resume(rst_resume), .rst_plat(rst_plat),
        .sleeping(sleeping), .sci_sel(sci_sel),
        .gpio_lvl(gpio_lvl), .gpio_dir_in(gpio_dir_in), .gpio_inv(gpio_inv),
        .usb_wake_req(usb_wake_req), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wake_o(wake_o), .sci_o(sci_o), .smi_o(smi_o)
    );

    typedef struct packed {
        logic [15:0] lvl;
        logic [15:0] dir;
        logic [15:0] inv;
        logic        usb;
        logic [31:0] exp;
    } vec_t;

    // R3/R4 vectors: expected status after one edge from a cleared register.
    localparam vec_t VECS [6] = '{
        '{16'h0001, 16'hFFFF, 16'h0000, 1'b0, 32'h0001_0000},
        '{16'h0000, 16'hFFFF, 16'h0000, 1'b0, 32'h0000_0000},
        '{16'h0000, 16'h8000, 16'h8000, 1'b0, 32'h8000_0000},
        '{16'hFFFF, 16'h00FF, 16'h0000, 1'b1, 32'h00FF_0100},
        '{16'hA5A5, 16'hFFFF, 16'hFFFF, 1'b0, 32'h5A5A_0000},
        '{16'h1234, 16'hF0F0, 16'h0F00, 1'b1, 32'h1030_0100}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic sources_off();
        gpio_dir_in = '0; gpio_lvl = '0; gpio_inv = '0; usb_wake_req = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst_resume = 1'b1; rst_plat = 1'b0; sleeping = 1'b0; sci_sel = 1'b1;
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        sources_off();
        gpio_dir_in = 16'hFFFF; gpio_lvl = 16'hFFFF; usb_wake_req = 1'b1;
        tick(); tick();
        // R1: reset holds everything clear even with sources active
        rd(1'b0, d); check("R1 status", d, 32'h0);
        rd(1'b1, d); check("R1 enable", d, 32'h0);
        check("R1 outputs", {29'h0, wake_o, sci_o, smi_o}, 32'h0);
        sources_off();
        rst_resume = 1'b0;
        tick();

        // R3/R4 table walk
        foreach (VECS[i]) begin
            sources_off();
            wr(1'b0, 32'hFFFF_FFFF);
            gpio_lvl = VECS[i].lvl; gpio_dir_in = VECS[i].dir;
            gpio_inv = VECS[i].inv; usb_wake_req = VECS[i].usb;
            tick();
            sources_off();
            rd(1'b0, d); check("R3/R4 vector", d, VECS[i].exp);
        end

        // R7/R10: enable register masks reserved bits
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, d); check("R7 R10 enable readback", d, 32'hFFFF_0100);
        wr(1'b1, 32'h0);
        // R7: status reserved bits read zero after clear
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, d); check("R7 status reserved", d, 32'h0);

        // R6: sticky after source goes away
        gpio_dir_in = 16'h0001; gpio_lvl = 16'h0001;
        tick();
        sources_off();
        tick(); tick();
        rd(1'b0, d); check("R6 sticky", d, 32'h0001_0000);
        // R5: writing zero keeps, writing one clears
        wr(1'b0, 32'h0000_0000);
        rd(1'b0, d); check("R5 write zero keeps", d, 32'h0001_0000);
        wr(1'b0, 32'h0001_0000);
        rd(1'b0, d); check("R5 write one clears", d, 32'h0);
        // R5: set wins over same-cycle clear
        gpio_dir_in = 16'h0002; gpio_lvl = 16'h0002;
        wr(1'b0, 32'h0002_0000);
        sources_off();
        rd(1'b0, d); check("R5 set wins", d, 32'h0002_0000);
        wr(1'b0, 32'hFFFF_FFFF);

        // R8/R9: routing of enabled events
        wr(1'b1, 32'h0001_0000);
        gpio_dir_in = 16'h0002; gpio_lvl = 16'h0002;
        tick();
        sources_off();
        sleeping = 1'b1; #1;
        check("R8 disabled bit no output", {29'h0, wake_o, sci_o, smi_o}, 32'h0);
        gpio_dir_in = 16'h0001; gpio_lvl = 16'h0001;
        tick();
        sources_off();
        check("R8 wake while sleeping", {29'h0, wake_o, sci_o, smi_o}, 32'h4);
        sleeping = 1'b0; sci_sel = 1'b1; #1;
        check("R9 sci in working", {29'h0, wake_o, sci_o, smi_o}, 32'h2);
        sci_sel = 1'b0; #1;
        check("R9 smi in working", {29'h0, wake_o, sci_o, smi_o}, 32'h1);
        wr(1'b0, 32'h0001_0000);
        check("R9 cleared drops output", {29'h0, wake_o, sci_o, smi_o}, 32'h0);

        // R2: platform reset clears GPIO half only
        wr(1'b0, 32'hFFFF_FFFF);
        wr(1'b1, 32'h00F0_0100);
        gpio_dir_in = 16'h0030; gpio_lvl = 16'h0030; usb_wake_req = 1'b1;
        tick();
        sources_off();
        rd(1'b0, d); check("R2 pre status", d, 32'h0030_0100);
        rst_plat = 1'b1;
        tick();
        rst_plat = 1'b0;
        rd(1'b0, d); check("R2 status low kept", d, 32'h0000_0100);
        rd(1'b1, d); check("R2 enable kept", d, 32'h00F0_0100);

        // R1: resume reset clears all
        rst_resume = 1'b1;
        tick();
        rst_resume = 1'b0;
        rd(1'b0, d); check("R1 status after resume", d, 32'h0);
        rd(1'b1, d); check("R1 enable after resume", d, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule